// File: doc/BRIEF.md
# HDLC Receive Bit Deframer

This block recovers HDLC-style frames from a received serial stream that arrives one bit per handshake. While it is hunting, it throws away every bit until it sees a flag. Inside a frame it deletes the zeros that the transmitter stuffed in. It packs the remaining bits into bytes and emits them on a byte stream. Each byte carries start-of-frame, end-of-frame and abort markers. The block also watches for runs of ones. A run that comes right after a flag is treated as idle fill and dropped without any report. A run that comes later in a frame aborts that frame, and the block counts the abort.

Both sides of the block use valid/ready handshakes. The block accepts an input bit only when its single output register is empty or is being emitted in the same cycle. A stalled output therefore stops the input at once, and nothing is lost or reordered. A bypass mode turns off all framing work and simply packs every bit into bytes. Bit-order reversal still applies in bypass mode.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, out_valid is 0, abort_count is 0 and in_ready is 1. The block then hunts: until a flag arrives, no input bit produces any output.
- R2: A flag is the bit sequence 0, six ones, 0 (0x7E). Flags are never output. The complete bytes between an opening flag and a closing flag are output in order. The first of them has out_sof=1, the last has out_eof=1, and a one-byte frame has both set.
- R3: Inside a frame, a 0 that directly follows five consecutive ones is deleted before bytes are formed.
- R4: A single flag can close one frame and open the next one. A flag that follows another flag, with no complete byte between them, produces no output.
- R5: If seven consecutive ones finish within the first 16 input bits after a flag, the block treats them as idle fill. It outputs nothing from that frame, leaves abort_count unchanged, and hunts for the next flag.
- R6: If seven consecutive ones finish later than 16 bits after a flag, the frame is aborted and abort_count goes up by one. If the frame has a complete byte held, that byte is output with out_eof=1 and out_abort=1. The block then hunts for the next flag.
- R7: By default, the first bit received for a byte appears in out_data[7]. When lsb_first=1, it appears in out_data[0].
- R8: When proc_en=0, every eight accepted bits form one output byte, with no flag, stuffing or run handling. The markers are 0, abort_count does not change, and R7 still applies.
- R9: While out_valid=1 and out_ready=0, in_ready is 0 and out_data and the markers hold their values. The byte is consumed on the cycle where out_valid and out_ready are both 1.
- R10: Bits left over in a frame that do not fill a whole byte before the closing flag are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_en | input | 1 | 1: framing enabled; 0: bypass (pack bits only) |
| lsb_first | input | 1 | 1: the first received bit of each byte is its LSB |
| in_valid | input | 1 | Input bit is present |
| in_ready | output | 1 | Block can accept the input bit this cycle |
| in_bit | input | 1 | Received serial bit |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | BYTE_W | Output byte |
| out_sof | output | 1 | Byte is the first of its frame |
| out_eof | output | 1 | Byte is the last of its frame |
| out_abort | output | 1 | Frame ended by an abort (set only with out_eof) |
| abort_count | output | CNT_W | Number of aborted frames, wraps |

## Verification
The same flag can close one frame and open the next. Its last bit must both release the held byte with the end marker and restart byte assembly for the new frame. The bench provokes this by sending frames back to back that share one flag between them. It judges the result by the marker pattern: the last byte of the first frame carries only the end marker, and the first byte of the following frame carries the start marker. A second case has a stalled output while a closing flag is pending. Here the bench checks that the held byte stays stable and that the flag bit is accepted only after release.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [2:0] {
    BC_D0,
    BC_D1,
    BC_STUFF,
    BC_FLAG,
    BC_ABORT
  } bitclass_t;

  typedef enum logic {
    FS_HUNT,
    FS_OPEN
  } fstate_t;

endpackage

// File: rtl/hdlc_rx_bitclass.sv
module hdlc_rx_bitclass
  import hdlc_rx_pkg::*;
#(
  parameter int FLAG_ONES = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  input  logic      bit_i,
  output bitclass_t cls
);
  localparam int RUN_W = $clog2(FLAG_ONES + 2);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(FLAG_ONES + 1);
  localparam logic [RUN_W-1:0] FLAG_AT  = RUN_W'(FLAG_ONES);
  localparam logic [RUN_W-1:0] STUFF_AT = RUN_W'(FLAG_ONES - 1);

  logic [RUN_W-1:0] run_q;

  // classify the incoming bit from the ones run that precedes it
  always_comb begin
    if (bit_i)                cls = (run_q >= FLAG_AT) ? BC_ABORT : BC_D1;
    else if (run_q == FLAG_AT)  cls = BC_FLAG;
    else if (run_q == STUFF_AT) cls = BC_STUFF;
    else                        cls = BC_D0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (step) begin
      if (!bit_i)               run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + RUN_W'(1);
    end
  end

endmodule

// File: rtl/hdlc_rx_bitline.sv
module hdlc_rx_bitline #(
  parameter int DEPTH = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic bit_i,
  output logic pop_v,
  output logic pop_b
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] sh_q;
  logic [CW-1:0]    cnt_q;

  // a bit leaves only once DEPTH newer bits prove it was not part of a flag
  assign pop_v = push && (cnt_q == CW'(DEPTH));
  assign pop_b = sh_q[DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (push) begin
      sh_q <= {sh_q[DEPTH-2:0], bit_i};
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/hdlc_rx_packer.sv
module hdlc_rx_packer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add,
  input  logic         bit_i,
  output logic         done,
  output logic [W-1:0] byte_o
);
  localparam int CW = $clog2(W);

  logic [W-2:0]  acc_q;
  logic [CW-1:0] cnt_q;

  assign done   = add && (cnt_q == CW'(W - 1));
  assign byte_o = {acc_q, bit_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (add) begin
      acc_q <= {acc_q[W-3:0], bit_i};
      cnt_q <= done ? '0 : cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int FLAG_LEN = 8,
  parameter int FILL_WIN = 16,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_en,
  input  logic              lsb_first,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_abort,
  output logic [CNT_W-1:0]  abort_count
);
  localparam int LINE_DEPTH = FLAG_LEN - 1;
  localparam int FLAG_ONES  = FLAG_LEN - 2;
  localparam int WIN_W      = $clog2(FILL_WIN + 1);
  localparam logic [WIN_W-1:0] WIN_END = WIN_W'(FILL_WIN);

  fstate_t           st_q;
  logic [WIN_W-1:0]  since_q;
  logic              hold_v, hold_sof, first_q;
  logic [BYTE_W-1:0] hold_d;
  logic [CNT_W-1:0]  abort_q;

  logic      acc;
  bitclass_t cls;
  logic      is_data, is_delim, late;
  logic      push, pop_v, pop_b, line_clr;
  logic      pack_add, pack_b, pack_clr, byte_done;
  logic [BYTE_W-1:0] byte_val;

  assign in_ready    = !out_valid || out_ready;
  assign acc         = in_valid && in_ready;
  assign abort_count = abort_q;

  hdlc_rx_bitclass #(.FLAG_ONES(FLAG_ONES)) u_cls (
    .clk(clk), .rst_n(rst_n), .step(acc), .bit_i(in_bit), .cls(cls)
  );

  assign is_data  = (cls == BC_D0) || (cls == BC_D1);
  assign is_delim = (cls == BC_FLAG) || (cls == BC_ABORT);
  assign late     = (since_q >= WIN_END);
  assign push     = acc && proc_en && (st_q == FS_OPEN) && is_data;
  assign line_clr = !proc_en || (acc && is_delim);

  hdlc_rx_bitline #(.DEPTH(LINE_DEPTH)) u_line (
    .clk(clk), .rst_n(rst_n), .clr(line_clr), .push(push), .bit_i(in_bit),
    .pop_v(pop_v), .pop_b(pop_b)
  );

  assign pack_add = proc_en ? pop_v : acc;
  assign pack_b   = proc_en ? pop_b : in_bit;
  assign pack_clr = acc && proc_en && is_delim;

  hdlc_rx_packer #(.W(BYTE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(pack_clr), .add(pack_add), .bit_i(pack_b),
    .done(byte_done), .byte_o(byte_val)
  );

  // emission decision for this cycle
  logic              emit, e_sof, e_eof, e_ab;
  logic [BYTE_W-1:0] e_d, e_rev;

  always_comb begin
    emit  = 1'b0;
    e_d   = hold_d;
    e_sof = hold_sof;
    e_eof = 1'b0;
    e_ab  = 1'b0;
    if (acc) begin
      if (!proc_en) begin
        emit  = byte_done;
        e_d   = byte_val;
        e_sof = 1'b0;
      end else if (st_q == FS_OPEN) begin
        case (cls)
          BC_FLAG:  begin emit = hold_v; e_eof = 1'b1; end
          BC_ABORT: begin emit = hold_v && late; e_eof = 1'b1; e_ab = 1'b1; end
          BC_D0, BC_D1: emit = hold_v && byte_done;
          default: ;
        endcase
      end
    end
  end

  for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_rev
    assign e_rev[gi] = e_d[BYTE_W-1-gi];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= FS_HUNT;
      since_q   <= '0;
      hold_v    <= 1'b0;
      hold_sof  <= 1'b0;
      hold_d    <= '0;
      first_q   <= 1'b0;
      abort_q   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_abort <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (emit) begin
        out_valid <= 1'b1;
        out_data  <= lsb_first ? e_rev : e_d;
        out_sof   <= e_sof;
        out_eof   <= e_eof;
        out_abort <= e_ab;
      end
      if (acc) begin
        if (!proc_en) begin
          st_q   <= FS_HUNT;
          hold_v <= 1'b0;
        end else if (st_q == FS_HUNT) begin
          if (cls == BC_FLAG) begin
            st_q    <= FS_OPEN;
            since_q <= '0;
            hold_v  <= 1'b0;
            first_q <= 1'b1;
          end
        end else begin
          if (!late) since_q <= since_q + WIN_W'(1);
          case (cls)
            BC_FLAG: begin
              hold_v  <= 1'b0;
              first_q <= 1'b1;
              since_q <= '0;
            end
            BC_ABORT: begin
              st_q   <= FS_HUNT;
              hold_v <= 1'b0;
              if (late) abort_q <= abort_q + CNT_W'(1);
            end
            BC_D0, BC_D1: begin
              if (byte_done) begin
                hold_d   <= byte_val;
                hold_sof <= first_q;
                first_q  <= 1'b0;
                hold_v   <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R9: a stalled byte keeps its value and markers
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof)
                                && $stable(out_eof) && $stable(out_abort));

  // R6: the abort marker only ever closes a frame
  a_r6_abort_is_eof: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_abort |-> out_eof);

  // R6: the counter moves by one and only out of an open frame
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q != $past(abort_q) |->
      (abort_q == $past(abort_q) + CNT_W'(1)) && ($past(st_q) == FS_OPEN)
      && $past(proc_en));

  // R1: while hunting with framing on, nothing new appears at the output
  a_r1_hunt_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !$past(proc_en) || ($past(st_q) == FS_OPEN));

endmodule

// File: tb/tb_hdlc_rx_deframer.sv
module tb_hdlc_rx_deframer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proc_en = 1'b1, lsb_first = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_sof, out_eof, out_abort;
  logic [7:0] out_data;
  logic [CNT_W-1:0] abort_count;

  int checks = 0;
  int errors = 0;
  int tx_ones = 0;
  logic [10:0] rxq[$];
  logic bp_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_deframer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .proc_en(proc_en), .lsb_first(lsb_first),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_abort(out_abort),
    .abort_count(abort_count)
  );

  // tags packed as {sof, eof, abort, data}
  always @(negedge clk)
    if (rst_n && out_valid && out_ready)
      rxq.push_back({out_sof, out_eof, out_abort, out_data});

  // {lsb_first, bits in send order (bit 7 first), expected out_data}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'hA5, 8'hA5}, {1'b1, 8'h80, 8'h01}, {1'b0, 8'hFF, 8'hFF},
    {1'b1, 8'hF0, 8'h0F}, {1'b0, 8'h7E, 8'h7E}, {1'b0, 8'h00, 8'h00},
    {1'b1, 8'h3C, 8'h3C}, {1'b1, 8'hC1, 8'h83}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_byte(input string req, input logic [10:0] exp);
    if (rxq.size() == 0) begin
      checks++;
      errors++;
      $display("FAIL %s: actual none expected %0h", req, exp);
    end else begin
      chk(req, 32'(rxq.pop_front()), 32'(exp));
    end
  endtask

  task automatic expect_empty(input string req);
    chk(req, rxq.size(), 0);
    rxq.delete();
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    logic rdy;
    in_valid = 1'b1;
    in_bit = b;
    do begin
      @(negedge clk);
      rdy = in_ready;
      @(posedge clk);
      #1;
    end while (!rdy);
    in_valid = 1'b0;
  endtask

  task automatic send_raw(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_flag();
    send_raw(8'h7E);
    tx_ones = 0;
  endtask

  task automatic send_data_bit(input logic b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin
        send_bit(1'b0);
        tx_ones = 0;
      end
    end else begin
      tx_ones = 0;
    end
  endtask

  task automatic send_data(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_data_bit(v[i]);
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0;
    proc_en = mode;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    rxq.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 abort_count", abort_count, 0);
    chk("R1 in_ready", in_ready, 1);
    idle(1);
    send_raw(8'hA5);
    send_raw(8'h3C);
    idle(3);
    expect_empty("R1 hunt before flag");

    // table walk: one-byte frames, stuffing and bit order (R2, R3, R7)
    for (int i = 0; i < 8; i++) begin
      lsb_first = VEC[i][16];
      send_flag();
      send_data(VEC[i][15:8]);
      send_flag();
      idle(3);
      expect_byte("R2/R3/R7 table", {3'b110, VEC[i][7:0]});
    end
    lsb_first = 1'b0;

    // shared flags and empty frames (R4)
    send_flag();
    send_data(8'h12);
    send_data(8'h34);
    send_flag();
    send_data(8'h56);
    send_flag();
    send_flag();
    send_flag();
    idle(3);
    expect_byte("R4 first frame sof", 11'h412);
    expect_byte("R4 first frame eof", 11'h234);
    expect_byte("R4 next frame", 11'h656);
    expect_empty("R4 repeated flags");

    // leftover bits before closing flag (R10)
    send_flag();
    send_data(8'hAB);
    send_data_bit(1'b1);
    send_data_bit(1'b0);
    send_data_bit(1'b1);
    send_flag();
    idle(3);
    expect_byte("R10 residue dropped", 11'h6AB);
    expect_empty("R10 nothing extra");

    // early ones after a flag are fill (R5)
    send_flag();
    send_raw(8'hFE);
    send_raw(8'hA5);
    idle(3);
    expect_empty("R5 fill silent");
    send_flag();
    send_data(8'h5A);
    send_flag();
    idle(3);
    expect_byte("R5 recovery", 11'h65A);
    chk("R5 count unchanged", abort_count, 0);

    // late ones abort the frame (R6)
    send_flag();
    send_data(8'h11);
    send_data(8'h22);
    send_data(8'h30);
    send_raw(8'hFE);
    idle(3);
    expect_byte("R6 first byte", 11'h411);
    expect_byte("R6 abort tagged", 11'h322);
    chk("R6 count", abort_count, 1);
    send_raw(8'h0F);
    idle(3);
    expect_empty("R6 discard until flag");
    send_flag();
    send_data(8'h44);
    send_flag();
    idle(3);
    expect_byte("R6 after abort", 11'h644);

    // back-pressure (R9)
    do_reset(1'b1);
    out_ready = 1'b0;
    fork
      begin
        send_flag();
        send_data(8'h12);
        send_data(8'h34);
        send_flag();
        bp_done = 1'b1;
      end
    join_none
    for (int k = 0; k < 200 && !out_valid; k++) idle(1);
    idle(5);
    @(negedge clk);
    chk("R9 valid held", out_valid, 1);
    chk("R9 data held", {out_sof, out_eof, out_abort, out_data}, 11'h412);
    chk("R9 in_ready low", in_ready, 0);
    idle(1);
    out_ready = 1'b1;
    wait (bp_done);
    idle(3);
    expect_byte("R9 first after release", 11'h412);
    expect_byte("R9 second after release", 11'h234);

    // bypass (R8)
    do_reset(1'b0);
    send_raw(8'h7E);
    send_raw(8'hFF);
    send_raw(8'hF8);
    idle(3);
    expect_byte("R8 flag pattern as data", 11'h07E);
    expect_byte("R8 ones as data", 11'h0FF);
    expect_byte("R8 no destuff", 11'h0F8);
    chk("R8 count unchanged", abort_count, 0);
    lsb_first = 1'b1;
    send_raw(8'h80);
    idle(3);
    expect_byte("R8 reorder in bypass", 11'h001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule